// File: doc/BRIEF.md
# Byte-level SMBus master controller with status codes

This block is a master-side SMBus/I2C engine that software steers one bus event at a time. Software writes a byte into a data register and a small control word made of a start request, a stop request and an acknowledge-enable. The controller then generates START, repeated START and STOP conditions, or shifts one 9-bit byte slot on the bus. When the event completes it raises SI, posts an 8-bit status code and holds SCL low. It keeps SCL low until software writes the control word again, and that write also clears SI.

Each status code is a multiple of eight, so software can use it directly as a jump index. An address byte with its LSB set switches the controller into receive mode. In that mode each following byte slot samples data from the slave, and the controller returns ACK or NACK as the acknowledge-enable bit selects. The controller checks every bit it sends as a 1. If another device holds SDA low on such a bit, the controller gives up the bus and reports arbitration loss. A divider input sets the SCL period.

Top module: `smb_byte_ctrl`

## Requirements
- R1: From idle, a control write with the start request set makes the controller drop SDA while SCL is high, then pull SCL low, set SI and post status 08h.
- R2: With SI set, a control write with start=1 and stop=0 makes the controller release SDA, release SCL and then drop SDA with SCL high (a repeated START), and then post status 10h.
- R3: A byte sent in status 08h or 10h is an address. If its LSB is 0, an ACK gives status 18h and a NACK gives 20h. If its LSB is 1, an ACK gives status 40h, a NACK gives 48h, and the controller enters receive mode.
- R4: A control write with start=0 and stop=0 in transmit mode sends the data register. An ACK gives status 28h and a NACK gives 30h.
- R5: In receive mode, a control write with start=0 and stop=0 clocks in one byte. The controller drives ACK (SDA low) when acknowledge-enable was 1, which gives status 50h, and leaves SDA released otherwise, which gives status 58h.
- R6: A control write with stop=1 makes the controller raise SDA while SCL is high (a STOP). It then goes idle with SI at 0 and does not latch the stop request. If start was also 1, a START follows and status 08h is posted.
- R7: While SI is 1, apart from status 38h, SCL is driven low and neither bus line changes until the next control write.
- R8: Bytes leave the data register MSB first, and each sampled bus bit enters at the LSB. After a byte slot, the register holds the byte that was on the bus.
- R9: Data register writes are accepted only while SI is 1 or the controller is idle. A write made while a byte is shifting has no effect.
- R10: Status bits 2:0 are always 0. The status reads F8h whenever SI is 0, including after reset.
- R11: If SDA reads low during a data or address bit that the controller sends as 1, the controller releases both lines, sets SI and posts 38h. A control write then returns it to idle, or starts again if start=1.
- R12: The SCL period during a byte is 4*(div_i+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Quarter-bit divider; SCL period is 4*(div_i+1) cycles |
| dat_we_i | input | 1 | Data register write strobe |
| dat_i | input | BYTE_W | Data register write value |
| dat_o | output | BYTE_W | Data register contents |
| ctrl_we_i | input | 1 | Control write strobe; clears SI and starts the next action |
| sta_i | input | 1 | Start request bit of the control write |
| sto_i | input | 1 | Stop request bit of the control write |
| aa_i | input | 1 | Acknowledge-enable bit of the control write |
| si_o | output | 1 | Event flag; set when an action completes |
| status_o | output | 8 | Status code, multiple of eight |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that software writes the control word only while SI is 1 or while the controller is idle. They also assume that other devices change SDA only while SCL is low, except for a deliberate arbitration collision. The bench slave follows both rules. It changes its drive only at SCL falling edges or while SI holds SCL low, and software actions are sequenced on SI. The one deliberate violation is releasing SDA after an arbitration loss, when the controller no longer drives the bus.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RSTART, S_BYTE, S_STOP, S_WAIT, S_LOST
  } seq_e;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NACK = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NACK = 8'h58;
  localparam logic [7:0] ST_NONE    = 8'hF8;
endpackage

// File: rtl/smb_tick_gen.sv
`timescale 1ns/1ps
module smb_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smb_shifter.sv
`timescale 1ns/1ps
module smb_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         sh_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= ld_val_i;
    else if (sh_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/smb_byte_ctrl.sv
`timescale 1ns/1ps
module smb_byte_ctrl
  import smb_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              dat_we_i,
  input  logic [BYTE_W-1:0] dat_i,
  output logic [BYTE_W-1:0] dat_o,
  input  logic              ctrl_we_i,
  input  logic              sta_i,
  input  logic              sto_i,
  input  logic              aa_i,
  output logic              si_o,
  output logic [7:0]        status_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);

  seq_e        state_q;
  logic [1:0]  q_q;
  logic [CW-1:0] bit_q;
  logic        si_q, scl_q, sda_q, rx_q, addr_q, aa_q, pend_q, ack_q;
  logic [7:0]  status_q;
  logic [BYTE_W-1:0] dat_q;
  logic        tick, busy, tx, drv_low, is_addr_slot, dat_ld, dat_sh;
  logic [7:0]  end_code;

  assign busy = (state_q == S_START) || (state_q == S_RSTART) ||
                (state_q == S_BYTE)  || (state_q == S_STOP);
  assign tx           = !rx_q || addr_q;
  assign is_addr_slot = (status_q == ST_START) || (status_q == ST_RSTART);
  assign dat_ld = dat_we_i && (si_q || state_q == S_IDLE);
  assign dat_sh = tick && (state_q == S_BYTE) && (q_q == 2'd2) && (bit_q < ACK_SLOT);

  smb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(busy), .div_i, .tick_o(tick)
  );

  smb_shifter #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .ld_i(dat_ld), .ld_val_i(dat_i),
    .sh_i(dat_sh), .bit_i(sda_i), .q_o(dat_q)
  );

  // SDA drive for the current bit slot
  always_comb begin
    if (bit_q < ACK_SLOT) drv_low = tx ? !dat_q[BYTE_W-1] : 1'b0;
    else                  drv_low = tx ? 1'b0 : aa_q;
  end

  always_comb begin
    if (addr_q)    end_code = rx_q ? (ack_q ? ST_AR_ACK : ST_AR_NACK)
                                   : (ack_q ? ST_AW_ACK : ST_AW_NACK);
    else if (rx_q) end_code = aa_q ? ST_RX_ACK : ST_RX_NACK;
    else           end_code = ack_q ? ST_TX_ACK : ST_TX_NACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; q_q <= '0; bit_q <= '0;
      si_q <= 1'b0; status_q <= ST_NONE;
      scl_q <= 1'b0; sda_q <= 1'b0;
      rx_q <= 1'b0; addr_q <= 1'b0; aa_q <= 1'b0; pend_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (ctrl_we_i && sta_i) begin
          state_q <= S_START; q_q <= '0;
        end
        S_WAIT: if (ctrl_we_i) begin
          si_q <= 1'b0; status_q <= ST_NONE; q_q <= '0; pend_q <= sta_i;
          if (sto_i)      state_q <= S_STOP;
          else if (sta_i) state_q <= S_RSTART;
          else begin
            state_q <= S_BYTE; bit_q <= '0; aa_q <= aa_i; addr_q <= is_addr_slot;
            if (is_addr_slot) rx_q <= dat_q[0];
          end
        end
        S_LOST: if (ctrl_we_i) begin
          si_q <= 1'b0; status_q <= ST_NONE; q_q <= '0;
          state_q <= sta_i ? S_START : S_IDLE;
        end
        default: if (tick) begin
          q_q <= q_q + 2'd1;
          case (state_q)
            S_START: case (q_q)
              2'd0: begin scl_q <= 1'b0; sda_q <= 1'b0; end
              2'd1: sda_q <= 1'b1;
              2'd3: begin
                scl_q <= 1'b1; si_q <= 1'b1; status_q <= ST_START;
                state_q <= S_WAIT; rx_q <= 1'b0;
              end
              default: ;
            endcase
            S_RSTART: case (q_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin
                scl_q <= 1'b1; si_q <= 1'b1; status_q <= ST_RSTART;
                state_q <= S_WAIT; rx_q <= 1'b0;
              end
            endcase
            S_STOP: case (q_q)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: begin
                state_q <= pend_q ? S_START : S_IDLE;
                pend_q <= 1'b0; rx_q <= 1'b0;
              end
            endcase
            S_BYTE: case (q_q)
              2'd0: sda_q <= drv_low;
              2'd1: scl_q <= 1'b0;
              2'd2: begin
                if (bit_q < ACK_SLOT) begin
                  if (tx && !sda_q && !sda_i) begin  // lost arbitration
                    state_q <= S_LOST; scl_q <= 1'b0; sda_q <= 1'b0;
                    si_q <= 1'b1; status_q <= ST_ARB; rx_q <= 1'b0;
                  end
                end else begin
                  ack_q <= !sda_i;
                end
              end
              default: begin
                scl_q <= 1'b1;
                if (bit_q == ACK_SLOT) begin
                  si_q <= 1'b1; status_q <= end_code; state_q <= S_WAIT;
                end else begin
                  bit_q <= bit_q + 1'b1;
                end
              end
            endcase
            default: ;
          endcase
        end
      endcase
    end
  end

  assign dat_o    = dat_q;
  assign si_o     = si_q;
  assign status_o = status_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
endmodule

// File: rtl/smb_byte_ctrl_chk.sv
`timescale 1ns/1ps
module smb_byte_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dat_we_i,
  input logic [BYTE_W-1:0] dat_o,
  input logic              ctrl_we_i,
  input logic              si_o,
  input logic [7:0]        status_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o
);
  p_scl_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && status_o != 8'h38) |-> scl_oe_o);

  p_lines_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && !ctrl_we_i) |=> ($stable(sda_oe_o) && $stable(scl_oe_o)));

  p_dat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && !dat_we_i) |=> $stable(dat_o));

  p_code_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000);

  p_idle_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !si_o |-> status_o == 8'hF8);

  p_lost_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && status_o == 8'h38) |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind smb_byte_ctrl smb_byte_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/smb_byte_ctrl_test.sv
`timescale 1ns/1ps
module smb_byte_ctrl_test;
  localparam int DIV_W = 8;
  localparam int NV = 14;
  localparam int WD = 5000;

  // {dat/rx byte, ld, sta, sto, aa, slave mode, exp status, exp dat}
  // slave mode: 0 idle, 1 ack, 2 nack, 3 send byte, 4 hold SDA low on bit 0
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h08, 8'h00},
    {8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'h18, 8'hA0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'h28, 8'h3C},
    {8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'h30, 8'hC3},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h10, 8'hC3},
    {8'hA1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'h40, 8'hA1},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 8'h50, 8'h5A},
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 8'h58, 8'hA5},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h08, 8'hA5},
    {8'h90, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'h20, 8'h90},
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'hF8, 8'h90},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h08, 8'h90},
    {8'hFE, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 8'h38, 8'hFC},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'hF8, 8'hFC}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [DIV_W-1:0] div = 8'd2;
  logic dat_we = 1'b0, ctrl_we = 1'b0, sta = 1'b0, sto = 1'b0, aa = 1'b0;
  logic [7:0] dat_in = 8'h00;
  logic [7:0] dat_out, status;
  logic si, scl_oe, sda_oe;

  int unsigned smode = 0;
  logic [7:0] rx_byte = 8'h00;
  int idx_n = 0;
  int bc = 0;
  int n_start = 0, n_stop = 0;
  int checks = 0, fails = 0;
  logic slave_low;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slave_low);

  always_comb begin
    case (smode)
      1: slave_low = (idx_n == 8);
      3: slave_low = (idx_n < 8) && !rx_byte[7 - (idx_n % 8)];
      4: slave_low = (idx_n == 0);
      default: slave_low = 1'b0;
    endcase
  end

  always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin n_start++; bc = 0; end
  always @(posedge sda_line) if (rst_n && scl_line === 1'b1) n_stop++;
  always @(posedge scl_line) if (rst_n) bc++;
  always @(negedge scl_line) if (rst_n) idx_n = bc % 9;

  smb_byte_ctrl #(.DIV_W(DIV_W), .BYTE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div),
    .dat_we_i(dat_we), .dat_i(dat_in), .dat_o(dat_out),
    .ctrl_we_i(ctrl_we), .sta_i(sta), .sto_i(sto), .aa_i(aa),
    .si_o(si), .status_o(status),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_in = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic s, input logic p, input logic a);
    @(negedge clk); ctrl_we = 1'b1; sta = s; sto = p; aa = a;
    @(negedge clk); ctrl_we = 1'b0; sta = 1'b0; sto = 1'b0; aa = 1'b0;
  endtask

  task automatic wait_si(input string req);
    int t = 0;
    while (si !== 1'b1 && t < WD) begin @(negedge clk); t++; end
    check(t < WD, req, t, WD);
  endtask

  task automatic wait_idle();
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] got;
    realtime t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(si == 1'b0, "R10 si after reset", si, 0);
    check(status == 8'hF8, "R10 status after reset", status, 8'hF8);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released after reset", {scl_oe, sda_oe}, 0);
    check(dat_out == 8'h00, "R8 data after reset", dat_out, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      smode = v[19:16];
      if (v[19:16] == 4'd3) rx_byte = v[31:24];
      if (v[23]) wr_dat(v[31:24]);
      wr_ctrl(v[22], v[21], v[20]);
      if (v[15:8] == 8'hF8) begin
        wait_idle();
        check(si == 1'b0 && status == 8'hF8, "R6 idle after stop or release", status, 8'hF8);
        check(scl_line == 1'b1 && sda_oe == 1'b0, "R6 bus released", {scl_line, sda_oe}, 2'b10);
      end else begin
        wait_si("R1 event completes");
        check(status == v[15:8], "R3 R4 R5 status code", status, v[15:8]);
        if (v[15:8] == 8'h38)
          check(scl_oe == 1'b0 && sda_oe == 1'b0, "R11 lines released on loss", {scl_oe, sda_oe}, 0);
        else
          check(scl_line == 1'b0, "R7 SCL held low while SI", scl_line, 0);
      end
      check(dat_out == v[7:0], "R8 last byte on bus", dat_out, v[7:0]);
    end
    check(n_start == 4, "R1 R2 START count", n_start, 4);
    check(n_stop == 3, "R6 STOP count", n_stop, 3);

    // R9: write during a byte slot is ignored
    smode = 0;
    wr_ctrl(1'b1, 1'b0, 1'b0);
    wait_si("R1 start again");
    check(status == 8'h08, "R1 start status", status, 8'h08);
    wr_dat(8'hA0);
    smode = 1;
    wr_ctrl(1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    wr_dat(8'h11);
    wait_si("R9 address done");
    check(status == 8'h18, "R3 address ack", status, 8'h18);
    check(dat_out == 8'hA0, "R9 busy write ignored", dat_out, 8'hA0);

    // R12 period and R8 MSB-first order on the wire
    wr_dat(8'h55);
    div = 8'd5;
    wr_ctrl(1'b0, 1'b0, 1'b0);
    got = 8'h00;
    t1 = 0; t2 = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge scl_line);
      if (k == 0) t1 = $realtime;
      if (k == 1) t2 = $realtime;
      got = {got[6:0], sda_line};
    end
    check((t2 - t1) == 120.0, "R12 SCL period", int'(t2 - t1), 120);
    check(got == 8'h55, "R8 MSB first on bus", got, 8'h55);
    wait_si("R4 data done");
    check(status == 8'h28, "R4 data ack", status, 8'h28);

    smode = 0;
    wr_ctrl(1'b0, 1'b1, 1'b0);
    wait_idle();
    check(si == 1'b0 && status == 8'hF8, "R6 final stop", status, 8'hF8);
    check(n_start == 5 && n_stop == 4, "R6 final edge counts", {n_start[15:0], n_stop[15:0]}, {16'd5, 16'd4});

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule